// File: doc/BRIEF.md
# Capability Dword Window Port

This block gives software indirect reach into a controller's memory-mapped register bank through a small eight-byte window in configuration space. Software writes a dword select byte, and a 32-bit data register in the window then mirrors the bank dword at byte address select times four. A write to the data register is pushed into that bank dword. The bank's own per-bit write mask and write-one-to-clear mask govern that write.

The window sits between a dword-wide configuration read/write port and a register bank interface. Bank reads are asynchronous. The block computes the merged bank byte itself and issues a byte-enabled write.

Any accepted write that hits the window starts a fixed two-cycle sequence. The first cycle carries the forwarded bank write, when one is due. The second cycle reloads the data register from the selected bank dword. The port holds its ready output low for both cycles.

Lanes at or beyond the bank size are never written and reload as zero. A dword that straddles the end of the bank is therefore truncated.

Top module: `cwin_port`

## Requirements
- R1: After reset the select byte and the data register are zero, a read of either window dword returns zero, ready is high and no bank write is issued.
- R2: The window is two dword-aligned addresses, CAP_BASE and CAP_BASE+4. The dword at CAP_BASE holds the select in bits [23:16] and a read-only flag byte in bits [31:24], and reads zero in bits [15:0]. The flag byte reads zero and ignores writes. Reads of any other or misaligned address return zero.
- R3: A write to CAP_BASE with byte enable 2 set loads the select from write data bits [23:16]. After any write that hits the window, the data register reads the bank dword at byte address select*4 (bank_addr_o = select*4).
- R4: A write to CAP_BASE+4 with at least one byte enable set updates the enabled data-register bytes. The whole 32-bit data register is then forwarded as one bank write to byte address select*4, issued exactly once.
- R5: Each written bank byte becomes (old & ~wmask) | (data & wmask). Bits outside both masks keep their old value.
- R6: After the merge, every bit set in both the forwarded data and the write-one-to-clear mask is cleared in the bank.
- R7: A bank byte lane whose byte address is at or beyond BANK_BYTES is never written, and it reloads into the data register as zero. A select wholly beyond the bank reads zero and writes nothing.
- R8: After an accepted window write, ready is low for exactly two cycles. Requests presented while ready is low are ignored.
- R9: A write that misses the window changes nothing and does not drop ready.
- R10: Reads change no state and do not drop ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_req_i | input | 1 | Configuration access request |
| cfg_we_i | input | 1 | 1 = write, 0 = read |
| cfg_addr_i | input | CFG_AW | Configuration byte address (dword aligned) |
| cfg_be_i | input | 4 | Byte enables of the write |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data, valid while a read is presented |
| cfg_ready_o | output | 1 | High when a request is accepted |
| bank_addr_o | output | SEL_W+2 | Bank byte address, select*4 |
| bank_rdata_i | input | 32 | Bank dword at bank_addr_o (asynchronous) |
| bank_wmask_i | input | 32 | Bank write mask at bank_addr_o |
| bank_w1cmask_i | input | 32 | Bank write-one-to-clear mask at bank_addr_o |
| bank_we_o | output | 1 | Bank write strobe |
| bank_be_o | output | 4 | Bank byte lanes written |
| bank_wdata_o | output | 32 | Merged bank write data |

## Verification
The bench builds the block with BANK_BYTES = 22 and CAP_BASE = 0x40. Because 22 is not a multiple of four, select 5 straddles the end of the bank and exercises the truncated two-lane case. Select 200 lies wholly outside the bank. The bench's bank model returns 0xEE on lanes outside the bank, so a design that failed to zero those lanes would show up in a read. The bench's bank masks give each lane a different mix of writable, read-only and clear-on-one bits.

// File: rtl/cwin_pkg.sv
package cwin_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FWD  = 2'd1,
    ST_LOAD = 2'd2
  } win_state_e;

  localparam int unsigned NLANE    = 4;
  localparam int unsigned SEL_LANE = 2;
  localparam int unsigned DATA_OFS = 4;
endpackage

// File: rtl/cwin_decode.sv
module cwin_decode #(
  parameter int unsigned CFG_AW   = 8,
  parameter int unsigned CAP_BASE = 'h48
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic              ready_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [3:0]        be_i,
  output logic              hit_ctrl_o,
  output logic              hit_data_o,
  output logic              wr_cap_o,
  output logic              wr_sel_o,
  output logic [3:0]        wr_data_be_o,
  output logic              fwd_req_o
);
  import cwin_pkg::*;

  localparam logic [CFG_AW-1:0] CTRL_ADDR = CFG_AW'(CAP_BASE);
  localparam logic [CFG_AW-1:0] DATA_ADDR = CFG_AW'(CAP_BASE + DATA_OFS);

  logic acc_wr;

  assign hit_ctrl_o   = (addr_i == CTRL_ADDR);
  assign hit_data_o   = (addr_i == DATA_ADDR);
  assign acc_wr       = req_i & we_i & ready_i;
  assign wr_cap_o     = acc_wr & (hit_ctrl_o | hit_data_o);
  assign wr_sel_o     = acc_wr & hit_ctrl_o & be_i[SEL_LANE];
  assign wr_data_be_o = be_i & {4{acc_wr & hit_data_o}};
  assign fwd_req_o    = |wr_data_be_o;
endmodule

// File: rtl/cwin_fsm.sv
module cwin_fsm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic fwd_req_i,
  output logic ready_o,
  output logic fwd_phase_o,
  output logic load_en_o
);
  import cwin_pkg::*;

  win_state_e state_q;
  logic       fwd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fwd_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_FWD;
          fwd_q   <= fwd_req_i;
        end
        ST_FWD:  state_q <= ST_LOAD;
        ST_LOAD: begin
          state_q <= ST_IDLE;
          fwd_q   <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o     = (state_q == ST_IDLE);
  assign fwd_phase_o = (state_q == ST_FWD) & fwd_q;
  assign load_en_o   = (state_q == ST_LOAD);
endmodule

// File: rtl/cwin_lane.sv
module cwin_lane #(
  parameter int unsigned SEL_W      = 8,
  parameter int unsigned BANK_BYTES = 160,
  parameter int unsigned LANE       = 0
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [7:0]       old_i,
  input  logic [7:0]       wmask_i,
  input  logic [7:0]       w1c_i,
  input  logic [7:0]       data_i,
  output logic             ok_o,
  output logic [7:0]       merged_o,
  output logic [7:0]       reload_o
);
  localparam logic [SEL_W+2:0] LIMIT = (SEL_W+3)'(BANK_BYTES);

  logic [SEL_W+2:0] byte_addr;
  logic [7:0]       kept;

  assign byte_addr = {1'b0, sel_i, 2'(LANE)};
  assign ok_o      = (byte_addr < LIMIT);
  // write mask merge first, then clear-on-one
  assign kept      = (old_i & ~wmask_i) | (data_i & wmask_i);
  assign merged_o  = kept & ~(data_i & w1c_i);
  assign reload_o  = ok_o ? old_i : 8'h00;
endmodule

// File: rtl/cwin_port.sv
module cwin_port #(
  parameter int unsigned CFG_AW     = 8,
  parameter int unsigned CAP_BASE   = 'h48,
  parameter int unsigned SEL_W      = 8,
  parameter int unsigned BANK_BYTES = 160
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_req_i,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [3:0]        cfg_be_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  output logic              cfg_ready_o,
  output logic [SEL_W+1:0]  bank_addr_o,
  input  logic [31:0]       bank_rdata_i,
  input  logic [31:0]       bank_wmask_i,
  input  logic [31:0]       bank_w1cmask_i,
  output logic              bank_we_o,
  output logic [3:0]        bank_be_o,
  output logic [31:0]       bank_wdata_o
);
  import cwin_pkg::*;

  localparam int unsigned SEL_POS = SEL_LANE * 8;

  logic [SEL_W-1:0] sel_q;
  logic [31:0]      data_q;
  logic [31:0]      reload;
  logic [3:0]       lane_ok;
  logic             hit_ctrl, hit_data, wr_cap, wr_sel, fwd_req;
  logic [3:0]       wr_data_be;
  logic             fwd_phase, load_en;

  cwin_decode #(.CFG_AW(CFG_AW), .CAP_BASE(CAP_BASE)) u_dec (
    .req_i        (cfg_req_i),
    .we_i         (cfg_we_i),
    .ready_i      (cfg_ready_o),
    .addr_i       (cfg_addr_i),
    .be_i         (cfg_be_i),
    .hit_ctrl_o   (hit_ctrl),
    .hit_data_o   (hit_data),
    .wr_cap_o     (wr_cap),
    .wr_sel_o     (wr_sel),
    .wr_data_be_o (wr_data_be),
    .fwd_req_o    (fwd_req)
  );

  cwin_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (wr_cap),
    .fwd_req_i   (fwd_req),
    .ready_o     (cfg_ready_o),
    .fwd_phase_o (fwd_phase),
    .load_en_o   (load_en)
  );

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    cwin_lane #(.SEL_W(SEL_W), .BANK_BYTES(BANK_BYTES), .LANE(k)) u_lane (
      .sel_i    (sel_q),
      .old_i    (bank_rdata_i[8*k +: 8]),
      .wmask_i  (bank_wmask_i[8*k +: 8]),
      .w1c_i    (bank_w1cmask_i[8*k +: 8]),
      .data_i   (data_q[8*k +: 8]),
      .ok_o     (lane_ok[k]),
      .merged_o (bank_wdata_o[8*k +: 8]),
      .reload_o (reload[8*k +: 8])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      data_q <= '0;
    end else begin
      if (wr_sel) sel_q <= cfg_wdata_i[SEL_POS +: SEL_W];
      for (int k = 0; k < NLANE; k++) begin
        if (wr_data_be[k]) data_q[8*k +: 8] <= cfg_wdata_i[8*k +: 8];
      end
      if (load_en) data_q <= reload;
    end
  end

  assign bank_addr_o = {sel_q, 2'b00};
  assign bank_we_o   = fwd_phase & (|lane_ok);
  assign bank_be_o   = bank_we_o ? lane_ok : 4'b0000;

  always_comb begin
    cfg_rdata_o = '0;
    if (cfg_req_i && !cfg_we_i) begin
      if (hit_ctrl)      cfg_rdata_o[SEL_POS +: SEL_W] = sel_q;
      else if (hit_data) cfg_rdata_o = data_q;
    end
  end
endmodule

// File: rtl/cwin_chk.sv
module cwin_chk #(
  parameter int unsigned CFG_AW   = 8,
  parameter int unsigned CAP_BASE = 'h48,
  parameter int unsigned SEL_W    = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_req_i,
  input logic              cfg_we_i,
  input logic [CFG_AW-1:0] cfg_addr_i,
  input logic              cfg_ready_o,
  input logic              bank_we_o,
  input logic [3:0]        bank_be_o,
  input logic [31:0]       bank_wdata_o,
  input logic [31:0]       bank_rdata_i,
  input logic [31:0]       bank_wmask_i,
  input logic [31:0]       bank_w1cmask_i,
  input logic [31:0]       win_data_i,
  input logic [SEL_W-1:0]  win_sel_i
);
  logic        cap_hit;
  logic [31:0] be_bits;

  assign cap_hit = (cfg_addr_i == CFG_AW'(CAP_BASE)) || (cfg_addr_i == CFG_AW'(CAP_BASE + 4));
  assign be_bits = {{8{bank_be_o[3]}}, {8{bank_be_o[2]}}, {8{bank_be_o[1]}}, {8{bank_be_o[0]}}};

  p_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_i && cfg_we_i && cfg_ready_o && cap_hit) |=> !cfg_ready_o);
  p_busy_min_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cfg_ready_o) |=> !cfg_ready_o);
  p_busy_max_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_ready_o && $past(!cfg_ready_o)) |=> cfg_ready_o);
  p_sel_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_ready_o |=> $stable(win_sel_i));
  p_miss_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_i && cfg_ready_o && !(cfg_we_i && cap_hit)) |=> cfg_ready_o);
  p_we_once_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_we_o |=> !bank_we_o);
  p_we_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_we_o |-> !cfg_ready_o);
  p_lanes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_we_o |-> (bank_be_o != 4'b0000));
  p_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_we_o |-> (((bank_wdata_o ^ bank_rdata_i) & ~(bank_wmask_i | bank_w1cmask_i) & be_bits) == 32'h0));
  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_we_o |-> ((bank_wdata_o & win_data_i & bank_w1cmask_i & be_bits) == 32'h0));
endmodule

bind cwin_port cwin_chk #(.CFG_AW(CFG_AW), .CAP_BASE(CAP_BASE), .SEL_W(SEL_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cfg_req_i      (cfg_req_i),
  .cfg_we_i       (cfg_we_i),
  .cfg_addr_i     (cfg_addr_i),
  .cfg_ready_o    (cfg_ready_o),
  .bank_we_o      (bank_we_o),
  .bank_be_o      (bank_be_o),
  .bank_wdata_o   (bank_wdata_o),
  .bank_rdata_i   (bank_rdata_i),
  .bank_wmask_i   (bank_wmask_i),
  .bank_w1cmask_i (bank_w1cmask_i),
  .win_data_i     (data_q),
  .win_sel_i      (sel_q)
);

// File: tb/sim_cwin_port.sv
`timescale 1ns/1ps
module sim_cwin_port;
  localparam int unsigned AW = 8;
  localparam int unsigned CB = 'h40;
  localparam int unsigned SW = 8;
  localparam int unsigned BB = 22;
  localparam logic [7:0] CTRL = 8'h40;
  localparam logic [7:0] DATA = 8'h44;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [3:0] be = '0;
  logic [31:0] wd = '0;
  logic [31:0] rdata, b_rd, b_wm, b_w1c, b_wd;
  logic ready, b_we;
  logic [3:0] b_be;
  logic [SW+1:0] b_addr;

  always #2.5 clk = ~clk;

  cwin_port #(.CFG_AW(AW), .CAP_BASE(CB), .SEL_W(SW), .BANK_BYTES(BB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_req_i(req), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_be_i(be), .cfg_wdata_i(wd), .cfg_rdata_o(rdata), .cfg_ready_o(ready),
    .bank_addr_o(b_addr), .bank_rdata_i(b_rd), .bank_wmask_i(b_wm),
    .bank_w1cmask_i(b_w1c), .bank_we_o(b_we), .bank_be_o(b_be), .bank_wdata_o(b_wd));

  // bank environment: per-lane mask mix, garbage beyond the end
  logic [7:0] mem [BB];
  logic [7:0] em  [BB];
  logic [7:0] esel = 8'h00;
  logic [31:0] edata = 32'h0;

  function automatic logic [7:0] wm_of(int a);
    case (a % 4) 0: return 8'hFF; 1: return 8'h0F; default: return 8'h00; endcase
  endfunction
  function automatic logic [7:0] w1c_of(int a);
    case (a % 4) 2: return 8'hFF; 3: return 8'hF0; default: return 8'h00; endcase
  endfunction

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      if (int'(b_addr) + k < BB) begin
        b_rd[8*k +: 8]  = mem[int'(b_addr) + k];
        b_wm[8*k +: 8]  = wm_of(int'(b_addr) + k);
        b_w1c[8*k +: 8] = w1c_of(int'(b_addr) + k);
      end else begin
        b_rd[8*k +: 8]  = 8'hEE;
        b_wm[8*k +: 8]  = 8'hFF;
        b_w1c[8*k +: 8] = 8'h00;
      end
    end
  end

  always @(posedge clk) begin
    if (b_we) begin
      for (int k = 0; k < 4; k++) begin
        if (b_be[k] && int'(b_addr) + k < BB) mem[int'(b_addr) + k] <= b_wd[8*k +: 8];
      end
    end
  end

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] exp_q [$];
  string tag_q [$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(logic [7:0] a);
    if (a == CTRL) return {8'h00, esel, 16'h0000};
    if (a == DATA) return edata;
    return 32'h0;
  endfunction

  // monitor: compares every presented read against the scoreboard queue
  always @(negedge clk) begin
    if (req && !we) begin
      if (exp_q.size() == 0) chk(1'b0, "read without expectation", rdata, 32'h0);
      else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(rdata === e, t, rdata, e);
      end
    end
  end

  task automatic cfg_read(input logic [7:0] a, input string tag);
    exp_q.push_back(exp_read(a));
    tag_q.push_back(tag);
    @(posedge clk); #1;
    req = 1'b1; we = 1'b0; addr = a; be = 4'hF;
    @(posedge clk); #1;
    req = 1'b0;
    chk(ready === 1'b1, "R10 ready after read", {31'b0, ready}, 32'h1);
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [3:0] b, input logic [31:0] d,
                           input bit stray);
    automatic bit touch = (a == CTRL) || (a == DATA);
    automatic bit fwd = 1'b0;
    if (a == CTRL && b[2]) esel = d[23:16];
    if (a == DATA) begin
      for (int k = 0; k < 4; k++) if (b[k]) begin edata[8*k +: 8] = d[8*k +: 8]; fwd = 1'b1; end
    end
    if (fwd) begin
      for (int k = 0; k < 4; k++) begin
        automatic int ba = int'(esel) * 4 + k;
        if (ba < BB) begin
          automatic logic [7:0] nb;
          for (int i = 0; i < 8; i++) begin
            nb[i] = wm_of(ba)[i] ? edata[8*k+i] : em[ba][i];
            if (w1c_of(ba)[i] && edata[8*k+i]) nb[i] = 1'b0;
          end
          em[ba] = nb;
        end
      end
    end
    if (touch) begin
      for (int k = 0; k < 4; k++) begin
        automatic int ba = int'(esel) * 4 + k;
        edata[8*k +: 8] = (ba < BB) ? em[ba] : 8'h00;
      end
    end
    @(posedge clk); #1;
    req = 1'b1; we = 1'b1; addr = a; be = b; wd = d;
    @(posedge clk); #1;
    if (stray) begin
      addr = CTRL; be = 4'b0100; wd = 32'h00AB_0000;
    end else req = 1'b0;
    if (touch) begin
      chk(ready === 1'b0, "R8 busy cycle 1", {31'b0, ready}, 32'h0);
      @(posedge clk); #1;
      req = 1'b0;
      chk(ready === 1'b0, "R8 busy cycle 2", {31'b0, ready}, 32'h0);
      @(posedge clk); #1;
      chk(ready === 1'b1, "R8 ready after two", {31'b0, ready}, 32'h1);
    end else begin
      chk(ready === 1'b1, "R9 miss keeps ready", {31'b0, ready}, 32'h1);
    end
  endtask

  task automatic chk_bank(input string tag);
    for (int i = 0; i < BB; i++) chk(mem[i] === em[i], tag, 32'(mem[i]), 32'(em[i]));
  endtask

  initial begin
    for (int i = 0; i < BB; i++) begin
      mem[i] = 8'(i * 29 + 7);
      em[i]  = 8'(i * 29 + 7);
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(ready === 1'b1, "R1 ready at reset", {31'b0, ready}, 32'h1);
    chk(b_we === 1'b0, "R1 no bank write at reset", {31'b0, b_we}, 32'h0);
    cfg_read(CTRL, "R1 ctrl dword reset");
    cfg_read(DATA, "R1 data reset");
    // R2 addresses outside / misaligned
    cfg_read(8'h48, "R2 past window reads zero");
    cfg_read(8'h3C, "R2 before window reads zero");
    cfg_read(8'h45, "R2 misaligned reads zero");
    // R3 select and reload
    cfg_write(CTRL, 4'b0100, 32'h0001_0000, 1'b0);
    cfg_read(CTRL, "R3 select readback");
    cfg_read(DATA, "R3 mirror of dword 1");
    // R4 R5 R6 full forward with mixed masks
    cfg_write(DATA, 4'b1111, 32'hA5C3_3CF0, 1'b0);
    cfg_read(DATA, "R5 R6 merged dword 1");
    chk_bank("R5 R6 bank contents");
    // R4 partial write forwards whole register
    cfg_write(DATA, 4'b0001, 32'h0000_005A, 1'b0);
    cfg_read(DATA, "R4 partial forward");
    chk_bank("R4 bank after partial");
    // R2 flag byte ignores writes; select untouched without be[2]
    cfg_write(CTRL, 4'b1011, 32'hFFFF_FFFF, 1'b0);
    cfg_read(CTRL, "R2 flag byte stays zero");
    // R9 write missing the window
    cfg_write(8'h48, 4'b1111, 32'hFFFF_FFFF, 1'b0);
    cfg_write(8'h41, 4'b1111, 32'hFFFF_FFFF, 1'b0);
    cfg_read(DATA, "R9 data unchanged");
    chk_bank("R9 bank unchanged");
    // R7 truncated dword at the bank end
    cfg_write(CTRL, 4'b0100, 32'h0005_0000, 1'b0);
    cfg_read(DATA, "R7 upper lanes reload zero");
    cfg_write(DATA, 4'b1111, 32'hFFFF_FFFF, 1'b0);
    cfg_read(DATA, "R7 truncated write");
    chk_bank("R7 only in-range lanes written");
    // R7 wholly outside
    cfg_write(CTRL, 4'b0100, 32'h00C8_0000, 1'b0);
    cfg_read(DATA, "R7 outside reads zero");
    cfg_write(DATA, 4'b1111, 32'h1234_5678, 1'b0);
    cfg_read(DATA, "R7 outside write dropped");
    chk_bank("R7 bank untouched outside");
    // R8 request during busy is ignored
    cfg_write(CTRL, 4'b0100, 32'h0002_0000, 1'b1);
    cfg_read(CTRL, "R8 stray select ignored");
    cfg_write(DATA, 4'b0110, 32'h00FF_FF00, 1'b1);
    cfg_read(DATA, "R8 data after stray");
    chk_bank("R8 bank after stray");
    // R3 sweep of selects
    for (int s = 0; s < 6; s++) begin
      cfg_write(CTRL, 4'b0100, {8'h00, 8'(s), 16'h0000}, 1'b0);
      cfg_read(DATA, "R3 sweep mirror");
    end
    repeat (3) @(posedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule